// File: doc/BRIEF.md
# Synchronous Graphics DRAM Command Decoder

This block sits behind the control pins of a synchronous graphics DRAM. On every rising clock edge it samples the clock enable, chip select, row strobe, column strobe, write enable, the special-function pin, the bank select and address bit 9. It turns that pin pattern into exactly one registered command strobe, along with the qualifiers that go with the command. Downstream logic runs the actual array operations, timing checks and data movement.

The special-function pin extends the usual command set. It selects block write over plain write, and the special mode-register load over the ordinary one. On a row activation it enables masked writes. Address bit 9 selects precharge of all banks, and on column commands it requests auto-precharge. A per-bank open/closed register and a running burst counter let the decoder do three things. It refuses commands that do not fit the current bank state. It turns a clock-enable drop during a burst into clock suspend. It keeps frozen cycles from reaching the outputs.

Top module: `sgram_cmd_decode`

## Requirements
- R1: All outputs are registered: the pins sampled at edge k show up on the outputs right after edge k. `cmd_o` is one-hot or all zero. Bit indices: 0 deselect, 1 no-op, 2 activate, 3 read, 4 write, 5 block write, 6 precharge, 7 auto refresh, 8 self-refresh entry, 9 mode load, 10 special mode load, 11 burst stop, 12 power-down, 13 clock suspend.
- R2: With the clock enable high in this cycle and the previous one, chip select high gives deselect whatever the other pins are.
- R3: Chip select low with both strobes and write enable high is a no-op. All four low is a mode load when the special-function pin is low, and a special mode load when it is high. A mode load is refused unless every bank is closed.
- R4: Chip select and both strobes low with write enable high is auto refresh if the clock enable stays high. It is self-refresh entry if the clock enable falls. Both are refused while any bank is open.
- R5: Row strobe and write enable low, with column strobe high, is precharge. With address bit 9 high it closes every bank and raises `all_banks_o`. With bit 9 low it closes only the selected bank. Precharge also ends any burst.
- R6: Row strobe low with column strobe and write enable high is activate. It opens the selected bank, and `mask_wr_o` follows the special-function pin. Activating a bank that is already open is refused.
- R7: Column strobe low with row strobe high is a read when write enable is high. It is a write when write enable is low, or a block write if the special-function pin is high. `auto_pre_o` follows address bit 9, and auto-precharge closes the bank at once. A column command to a closed bank is refused.
- R8: Write enable low with both strobes high is burst stop when the special-function pin is low. With that pin high the code is undefined and is refused.
- R9: A read or write starts a burst that covers the next BURST_LEN-1 running edges, unless burst stop or precharge ends it first. Block write starts no burst. When the clock enable falls with any non-refresh pattern, the command is clock suspend inside a burst and power-down outside one.
- R10: An edge whose previous-cycle clock enable was low is frozen. No strobe or error is produced, and the bank and burst state do not change.
- R11: A refused command raises `err_o` for one cycle. It produces no strobe and no qualifier, and it leaves the bank state unchanged.
- R12: After reset the strobes, qualifiers and error are zero and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| dsf_i | input | 1 | Special-function pin |
| bank_i | input | BANK_W | Bank select |
| a9_i | input | 1 | Address bit 9 (all banks / auto-precharge) |
| cmd_o | output | 14 | One-hot command strobe |
| bank_o | output | BANK_W | Bank of the strobed command, else zero |
| all_banks_o | output | 1 | Precharge covers all banks |
| auto_pre_o | output | 1 | Column command carries auto-precharge |
| mask_wr_o | output | 1 | Activation enables masked write |
| err_o | output | 1 | Command refused |
| bank_open_o | output | NUM_BANKS | Open flag per bank |

## Verification
The hardest case to reach is a clock-enable drop that lands inside a read or write burst. It needs an open bank, a column command, and a falling clock enable within the next BURST_LEN-1 running edges. The same applies to the frozen edges that follow, during which a burst must neither advance nor end. Directed sequences open a bank, read, drop the clock enable on the next edge and hold it low through several conflicting patterns. A long run of seeded random pins follows, with chip select mostly low and the clock enable occasionally low, so that suspends, power-downs, refused commands and auto-precharge closings show up in many orders.

// File: rtl/sgram_cmd_pkg.sv
package sgram_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_BWR   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_AREF  = 4'd7,
    CMD_SREF  = 4'd8,
    CMD_MRS   = 4'd9,
    CMD_SMRS  = 4'd10,
    CMD_BST   = 4'd11,
    CMD_PDN   = 4'd12,
    CMD_SUSP  = 4'd13,
    CMD_BAD   = 4'd14
  } cmd_e;

  localparam int unsigned CMD_NUM = 14;
endpackage

// File: rtl/sgram_pin_decode.sv
module sgram_pin_decode
  import sgram_cmd_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic dsf_i,
  input  logic burst_i,
  output cmd_e cmd_o,
  output logic valid_o
);
  cmd_e sleep_cmd;

  always_comb begin
    sleep_cmd = burst_i ? CMD_SUSP : CMD_PDN;
    valid_o   = cke_prev_i;
    if (cs_n_i) begin
      cmd_o = cke_i ? CMD_DESEL : sleep_cmd;
    end else if ({ras_n_i, cas_n_i, we_n_i} == 3'b001) begin
      cmd_o = cke_i ? CMD_AREF : CMD_SREF;
    end else if (!cke_i) begin
      cmd_o = sleep_cmd;
    end else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b000:  cmd_o = dsf_i ? CMD_SMRS : CMD_MRS;
        3'b010:  cmd_o = CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = dsf_i ? CMD_BWR : CMD_WR;
        3'b110:  cmd_o = dsf_i ? CMD_BAD : CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sgram_bank_track.sv
module sgram_bank_track
  import sgram_cmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned CNT_W  = $clog2(BURST_LEN + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  cmd_e                 cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 a9_i,
  output logic                 illegal_o,
  output logic                 burst_o,
  output logic [NUM_BANKS-1:0] open_o
);
  logic [NUM_BANKS-1:0] open_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 sel_open, col_cmd, go;

  always_comb begin
    sel_open  = open_q[bank_i];
    col_cmd   = (cmd_i == CMD_RD) || (cmd_i == CMD_WR) || (cmd_i == CMD_BWR);
    illegal_o = valid_i && (
                  (cmd_i == CMD_BAD) ||
                  ((cmd_i == CMD_ACT) && sel_open) ||
                  (col_cmd && !sel_open) ||
                  (((cmd_i == CMD_MRS) || (cmd_i == CMD_AREF) || (cmd_i == CMD_SREF)) && (|open_q)));
    go        = valid_i && !illegal_o;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
      end else if (go) begin
        if (cmd_i == CMD_ACT && hit) open_q[b] <= 1'b1;
        else if (cmd_i == CMD_PRE && (a9_i || hit)) open_q[b] <= 1'b0;
        else if (col_cmd && a9_i && hit) open_q[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (go && (cmd_i == CMD_RD || cmd_i == CMD_WR)) cnt_q <= CNT_W'(BURST_LEN - 1);
      else if (go && (cmd_i == CMD_PRE || cmd_i == CMD_BST)) cnt_q <= '0;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign burst_o = (cnt_q != '0);
  assign open_o  = open_q;

  p_act_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && cmd_i == CMD_ACT) |=> open_q[$past(bank_i)]);
  p_pre_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && cmd_i == CMD_PRE && a9_i) |=> (open_q == '0));
  p_refused_keeps_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(open_q));
  p_burst_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BURST_LEN - 1));
  p_frozen_cnt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
endmodule

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_cmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic                 dsf_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 a9_i,
  output logic [CMD_NUM-1:0]   cmd_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic                 all_banks_o,
  output logic                 auto_pre_o,
  output logic                 mask_wr_o,
  output logic                 err_o,
  output logic [NUM_BANKS-1:0] bank_open_o
);
  logic cke_q, valid, illegal, burst, strobe;
  cmd_e cmd;
  logic [CMD_NUM-1:0] cmd_d;
  logic [BANK_W-1:0]  bank_d;
  logic               all_d, ap_d, mw_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  sgram_pin_decode u_pins (
    .cke_prev_i (cke_q),
    .cke_i      (cke_i),
    .cs_n_i     (cs_n_i),
    .ras_n_i    (ras_n_i),
    .cas_n_i    (cas_n_i),
    .we_n_i     (we_n_i),
    .dsf_i      (dsf_i),
    .burst_i    (burst),
    .cmd_o      (cmd),
    .valid_o    (valid)
  );

  sgram_bank_track #(
    .NUM_BANKS (NUM_BANKS),
    .BURST_LEN (BURST_LEN)
  ) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid),
    .cmd_i     (cmd),
    .bank_i    (bank_i),
    .a9_i      (a9_i),
    .illegal_o (illegal),
    .burst_o   (burst),
    .open_o    (bank_open_o)
  );

  always_comb begin
    strobe = valid && !illegal;
    cmd_d  = strobe ? (CMD_NUM'(1) << cmd) : '0;
    bank_d = strobe ? bank_i : '0;
    all_d  = strobe && (cmd == CMD_PRE) && a9_i;
    ap_d   = strobe && ((cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_BWR)) && a9_i;
    mw_d   = strobe && (cmd == CMD_ACT) && dsf_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= '0;
      bank_o      <= '0;
      all_banks_o <= 1'b0;
      auto_pre_o  <= 1'b0;
      mask_wr_o   <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      cmd_o       <= cmd_d;
      bank_o      <= bank_d;
      all_banks_o <= all_d;
      auto_pre_o  <= ap_d;
      mask_wr_o   <= mw_d;
      err_o       <= illegal;
    end
  end

  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));
  p_desel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_q && cke_i && cs_n_i) |=> cmd_o[CMD_DESEL]);
  p_nop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_q && cke_i && !cs_n_i && ras_n_i && cas_n_i && we_n_i) |=> cmd_o[CMD_NOP]);
  p_err_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cmd_o == '0 && !all_banks_o && !auto_pre_o && !mask_wr_o));
  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_q |=> (cmd_o == '0 && !err_o && $stable(bank_open_o)));
endmodule

// File: tb/sim_sgram_cmd_decode.sv
module sim_sgram_cmd_decode;
  localparam int BL = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, dsf, a9;
  logic [0:0] bank;
  logic [13:0] cmd_o;
  logic [0:0]  bank_o;
  logic all_o, ap_o, mw_o, err_o;
  logic [1:0] open_o;

  int errors = 0, checks = 0;
  bit m_open[2];
  int m_cnt = 0;
  bit m_ckp = 1'b1;

  always #2.5 clk = ~clk;

  sgram_cmd_decode #(.NUM_BANKS(2), .BURST_LEN(BL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .dsf_i(dsf), .bank_i(bank), .a9_i(a9),
    .cmd_o(cmd_o), .bank_o(bank_o), .all_banks_o(all_o), .auto_pre_o(ap_o),
    .mask_wr_o(mw_o), .err_o(err_o), .bank_open_o(open_o)
  );

  // Command codes follow the bit indices of R1; 14 is the undefined code.
  function automatic int decode(bit ckp, bit ck, bit cs, bit r, bit c, bit w, bit d, bit bur);
    if (!ckp) return -1;
    if (cs) return ck ? 0 : (bur ? 13 : 12);
    if ({r, c, w} == 3'b001) return ck ? 7 : 8;
    if (!ck) return bur ? 13 : 12;
    case ({r, c, w})
      3'b000: return d ? 10 : 9;
      3'b010: return 6;
      3'b011: return 2;
      3'b101: return 3;
      3'b100: return d ? 5 : 4;
      3'b110: return d ? 14 : 11;
      default: return 1;
    endcase
  endfunction

  function automatic string req_for(int c, bit ill);
    if (c < 0) return "R10";
    if (ill) return "R11";
    case (c)
      0: return "R2";
      1, 9, 10: return "R3";
      7, 8: return "R4";
      6: return "R5";
      2: return "R6";
      3, 4, 5: return "R7";
      11: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit ck, bit cs, bit r, bit c, bit w, bit d, bit bk, bit aa);
    int cc;
    bit ill, strobe, any_open, col;
    logic [13:0] e_cmd;
    logic [31:0] e_pack, a_pack;
    cc = decode(m_ckp, ck, cs, r, c, w, d, m_cnt != 0);
    any_open = m_open[0] | m_open[1];
    col = (cc == 3 || cc == 4 || cc == 5);
    ill = (cc == 14) || (cc == 2 && m_open[bk]) || (col && !m_open[bk]) ||
          ((cc == 9 || cc == 7 || cc == 8) && any_open);
    if (cc < 0) ill = 1'b0;
    strobe = (cc >= 0) && !ill;
    e_cmd = strobe ? (14'd1 << cc) : 14'd0;
    if (cc >= 0) begin
      if (strobe && cc == 2) m_open[bk] = 1'b1;
      if (strobe && cc == 6) begin
        if (aa) begin m_open[0] = 1'b0; m_open[1] = 1'b0; end
        else m_open[bk] = 1'b0;
      end
      if (strobe && col && aa) m_open[bk] = 1'b0;
      if (strobe && (cc == 3 || cc == 4)) m_cnt = BL - 1;
      else if (strobe && (cc == 6 || cc == 11)) m_cnt = 0;
      else if (m_cnt != 0) m_cnt--;
    end
    m_ckp = ck;
    e_pack = {7'd0, e_cmd, strobe ? bk : 1'b0, strobe && cc == 6 && aa,
              strobe && col && aa, strobe && cc == 2 && d, ill, m_open[1], m_open[0]};
    cke = ck; cs_n = cs; ras_n = r; cas_n = c; we_n = w; dsf = d; bank = bk; a9 = aa;
    @(posedge clk); #1;
    a_pack = {7'd0, cmd_o, bank_o, all_o, ap_o, mw_o, err_o, open_o};
    check(req_for(cc, ill), a_pack, e_pack);
    check("R1", 32'($countones(cmd_o) <= 1), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; dsf = 0; bank = 0; a9 = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R12", {18'd0, cmd_o, err_o, open_o}, 32'd0);
    check("R12", {29'd0, all_o, ap_o, mw_o}, 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    // directed corners
    step(1,1,0,0,0,1,1,1);   // R2 deselect, other pins ignored
    step(1,0,1,1,1,0,0,0);   // R3 nop
    step(1,0,0,1,1,1,0,0);   // R6 activate bank0 with masked write
    step(1,0,0,1,1,0,0,0);   // R6 re-activate refused
    step(1,0,1,0,1,0,1,0);   // R7 read to closed bank1 refused
    step(1,0,1,0,1,0,0,0);   // R7 read bank0, burst starts
    step(0,0,1,1,1,0,0,0);   // R9 suspend inside burst
    step(0,0,0,1,1,0,1,0);   // R10 frozen
    step(1,0,0,1,1,0,1,0);   // R10 still frozen (previous cke low)
    step(1,0,1,1,1,0,0,0);   // R3 nop, burst continues
    step(1,0,1,1,0,0,0,0);   // R8 burst stop
    step(1,0,1,1,0,1,0,0);   // R8 undefined code refused
    step(1,0,0,0,0,0,0,0);   // R3 mode load refused with bank open
    step(1,0,0,0,1,0,0,0);   // R4 refresh refused with bank open
    step(1,0,1,0,0,0,0,1);   // R7 write with auto-precharge closes bank0
    step(1,0,1,0,0,1,0,0);   // R7 block write to closed bank refused
    step(1,0,0,1,1,0,1,0);   // R6 activate bank1
    step(1,0,1,0,0,1,1,0);   // R7 block write bank1
    step(1,0,0,1,0,0,0,1);   // R5 precharge all
    step(1,0,0,0,0,0,0,0);   // R3 mode load
    step(1,0,0,0,0,1,1,1);   // R3 special mode load
    step(1,0,0,0,1,0,0,0);   // R4 auto refresh
    step(0,0,0,0,1,0,0,0);   // R4 self-refresh entry
    step(0,1,0,0,0,0,0,0);   // R10 frozen
    step(1,1,0,0,0,0,0,0);   // R10 exit edge frozen
    step(0,1,1,1,1,0,0,0);   // R9 power-down outside burst
    step(1,0,1,1,1,0,0,0);   // R10 frozen
    step(1,0,0,1,1,0,0,0);   // R6 activate bank0
    step(1,0,0,1,1,0,1,0);   // R6 activate bank1
    step(1,0,0,1,0,0,1,0);   // R5 precharge bank1 only
    step(1,0,1,0,0,0,0,0);   // R7 write bank0, burst
    step(1,0,0,1,0,0,1,0);   // R5 precharge bank1 ends burst
    step(0,0,1,1,1,0,0,0);   // R9 power-down after burst ended
    step(1,1,1,1,1,0,0,0);   // R10 frozen
    for (int i = 0; i < 4000; i++) begin
      step($urandom % 10 != 0, $urandom % 8 == 0, $urandom % 2, $urandom % 2,
           $urandom % 2, $urandom % 4 == 0, $urandom % 2, $urandom % 3 == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule